// File: doc/BRIEF.md
# Flash Reset and Sleep Controller

This block sits at the pin boundary of a NOR-style flash memory. It filters and sequences the hardware reset pin. It reports a ready/busy condition as an open-drain-style pull-low request. It puts the device into a low-power sleep state when the address bus stops moving, and it decides when the data bus may be driven. All of its timing is counted in clock cycles, set through parameters.

A reset pulse on `rst_pin_n` passes through a two-flop synchronizer. It takes effect only when it stays low for `RP_CYC` synchronized cycles. An accepted reset sends a single-cycle abort to the program/erase engine. If the engine was busy at that moment, the busy indication is stretched by a ready timer. Reads come back only after a recovery delay that begins when the pin returns high. Sleep depends only on the address bus. Once the address has held for the access time plus a margin, the last read data is frozen and kept on the bus for as long as output is enabled.

Top module: `flash_ctl_front`

## Requirements
- R1: `sleep` rises on the (ACC_CYC+MARGIN_CYC+1)-th rising edge counted from the first edge that samples a new address, provided the address does not change in between.
- R2: Sleep entry timing and staying asleep do not depend on `ce_n`, `we_n` or `oe_n`.
- R3: While `sleep` is high, `dq_out` holds the value it had at sleep entry, even if `array_rdata` changes.
- R4: The first edge that samples a different address clears `sleep`. Within three cycles `dq_out` shows the array data for the new address.
- R5: `dq_oe` is 0 whenever `oe_n` or `ce_n` is 1. With both at 0 and no reset activity, `dq_oe` is 1 and `dq_out` equals the array data for the current address.
- R6: When the synchronized reset pin has been low for RP_CYC consecutive edges, `engine_abort` goes high for exactly one cycle, and only once per low period.
- R7: A reset pulse shorter than RP_CYC synchronized cycles gives no abort, no busy and no recovery delay.
- R8: While the synchronized reset pin is low, `dq_oe` is 0 and a write (falling `we_n` with `ce_n` low) gives no `wr_strobe`.
- R9: If `engine_busy` is 1 at reset acceptance, `rb_busy` stays 1 for READY_CYC cycles after the abort, even after the engine drops its busy flag.
- R10: If `engine_busy` is 0 at reset acceptance, `rb_busy` stays 0 through the whole reset.
- R11: After an accepted reset, `dq_oe` first returns on the (RH_CYC+3)-th rising edge after the pin goes high. That count is two synchronizer stages, one edge to leave the held state, and RH_CYC recovery edges.
- R12: In normal operation, a falling `we_n` with `ce_n` low gives exactly one `wr_strobe` pulse, one cycle wide.
- R13: `rb_busy` is 1 whenever `engine_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Address bus |
| engine_busy | input | 1 | Program/erase engine running |
| array_rdata | input | DW | Read data from the array |
| dq_out | output | DW | Data to drive on the bus |
| dq_oe | output | 1 | Drive enable for the data bus (0 = high impedance) |
| rb_busy | output | 1 | Pull ready/busy low (1 = busy) |
| sleep | output | 1 | Automatic sleep active |
| engine_abort | output | 1 | One-cycle abort to the program/erase engine |
| wr_strobe | output | 1 | One-cycle write strobe to the command decoder |

## Verification
A stuck or miscounted address-stability counter shows up at once as `sleep` rising on the wrong edge. It also shows up as `dq_out` following or ignoring the array while it should be frozen. A reset sequencer left in the wrong state shows within a few cycles: a missing or doubled abort, `rb_busy` ending at the wrong edge, or `dq_oe` coming back too early or never. Each of these is checked at its exact edge count rather than inside a window, so an off-by-one in any counter is caught.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        RS_RUN     = 2'd0,
        RS_COUNT   = 2'd1,
        RS_HELD    = 2'd2,
        RS_RECOVER = 2'd3
    } rst_state_e;

    typedef struct packed {
        logic pin_low;
        logic block_rd;
        logic abort;
        logic timer_busy;
    } rst_stat_t;

    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RESET_VAL;
                else     chain[i] <= (i == 0) ? din : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/fsc_reset_seq.sv
module fsc_reset_seq
    import fsc_pkg::*;
#(
    parameter int RP_CYC    = 5,
    parameter int READY_CYC = 20,
    parameter int RH_CYC    = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_low,
    input  logic      engine_busy,
    output rst_stat_t stat
);
    localparam int WCW = cnt_bits(RP_CYC);
    localparam int RCW = cnt_bits(READY_CYC);
    localparam int HCW = cnt_bits(RH_CYC);
    localparam logic [WCW-1:0] WIDTH_LAST = WCW'(RP_CYC - 1);
    localparam logic [RCW-1:0] READY_LOAD = RCW'(READY_CYC);
    localparam logic [HCW-1:0] RH_LOAD    = HCW'(RH_CYC - 1);

    rst_state_e     state;
    logic [WCW-1:0] width_cnt;
    logic [RCW-1:0] ready_cnt;
    logic [HCW-1:0] rec_cnt;
    logic           abort_q;
    logic           accept;

    assign accept = (state == RS_COUNT) && pin_low && (width_cnt == WIDTH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RS_RUN;
            width_cnt <= '0;
            rec_cnt   <= '0;
            abort_q   <= 1'b0;
        end else begin
            abort_q <= accept;
            unique case (state)
                RS_RUN: begin
                    if (pin_low) begin
                        width_cnt <= WCW'(1);
                        state     <= (RP_CYC <= 1) ? RS_HELD : RS_COUNT;
                    end
                end
                RS_COUNT: begin
                    if (!pin_low)    state <= RS_RUN;
                    else if (accept) state <= RS_HELD;
                    else             width_cnt <= width_cnt + 1'b1;
                end
                RS_HELD: begin
                    if (!pin_low) begin
                        rec_cnt <= RH_LOAD;
                        state   <= RS_RECOVER;
                    end
                end
                RS_RECOVER: begin
                    if (pin_low) begin
                        width_cnt <= WCW'(1);
                        state     <= RS_COUNT;
                    end else if (rec_cnt == '0) begin
                        state <= RS_RUN;
                    end else begin
                        rec_cnt <= rec_cnt - 1'b1;
                    end
                end
                default: state <= RS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        ready_cnt <= '0;
        else if (accept && engine_busy) ready_cnt <= READY_LOAD;
        else if (ready_cnt != '0)       ready_cnt <= ready_cnt - 1'b1;
    end

    always_comb begin
        stat.pin_low    = pin_low;
        stat.block_rd   = pin_low || (state == RS_HELD) || (state == RS_RECOVER);
        stat.abort      = abort_q;
        stat.timer_busy = (ready_cnt != '0);
    end
endmodule

// File: rtl/fsc_sleep_mon.sv
module fsc_sleep_mon
    import fsc_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int SLEEP_CYC = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rdata,
    output logic          asleep,
    output logic [DW-1:0] held_data
);
    localparam int SCW = cnt_bits(SLEEP_CYC);
    localparam logic [SCW-1:0] SLEEP_AT = SCW'(SLEEP_CYC);

    logic [AW-1:0]  addr_q;
    logic [SCW-1:0] stable_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            stable_cnt <= '0;
        end else begin
            addr_q <= addr;
            if (addr != addr_q)            stable_cnt <= '0;
            else if (stable_cnt != SLEEP_AT) stable_cnt <= stable_cnt + 1'b1;
        end
    end

    assign asleep = (stable_cnt == SLEEP_AT);

    always_ff @(posedge clk) begin
        if (rst)          held_data <= '0;
        else if (!asleep) held_data <= rdata;
    end
endmodule

// File: rtl/flash_ctl_front.sv
module flash_ctl_front
    import fsc_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 8,
    parameter int RP_CYC     = 5,
    parameter int READY_CYC  = 20,
    parameter int RH_CYC     = 4,
    parameter int ACC_CYC    = 6,
    parameter int MARGIN_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_pin_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          engine_busy,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          rb_busy,
    output logic          sleep,
    output logic          engine_abort,
    output logic          wr_strobe
);
    localparam int SLEEP_CYC = ACC_CYC + MARGIN_CYC;

    logic      pin_s;
    logic      pin_low_s;
    rst_stat_t rstat;
    logic      we_prev;
    logic      wr_q;

    fsc_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_pin_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rst_pin_n),
        .dout (pin_s)
    );

    assign pin_low_s = !pin_s;

    fsc_reset_seq #(
        .RP_CYC    (RP_CYC),
        .READY_CYC (READY_CYC),
        .RH_CYC    (RH_CYC)
    ) u_rseq (
        .clk         (clk),
        .rst         (rst),
        .pin_low     (pin_low_s),
        .engine_busy (engine_busy),
        .stat        (rstat)
    );

    fsc_sleep_mon #(
        .AW        (AW),
        .DW        (DW),
        .SLEEP_CYC (SLEEP_CYC)
    ) u_sleep (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .rdata     (array_rdata),
        .asleep    (sleep),
        .held_data (dq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            we_prev <= 1'b1;
            wr_q    <= 1'b0;
        end else begin
            we_prev <= we_n;
            wr_q    <= we_prev && !we_n && !ce_n && !rstat.block_rd;
        end
    end

    assign wr_strobe    = wr_q;
    assign dq_oe        = !rstat.block_rd && !ce_n && !oe_n;
    assign rb_busy      = engine_busy || rstat.timer_busy;
    assign engine_abort = rstat.abort;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          oe_n,
    input logic          ce_n,
    input logic          engine_busy,
    input logic          pin_low,
    input logic          sleep,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe,
    input logic          rb_busy,
    input logic          engine_abort,
    input logic          wr_strobe
);
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst) engine_abort |=> !engine_abort); // R6
    AST_ABORT_AFTER_LOW: assert property (@(posedge clk) disable iff (rst) engine_abort |-> $past(pin_low)); // R6
    AST_WAKE_ON_ADDR: assert property (@(posedge clk) disable iff (rst) !$stable(addr) |=> !sleep); // R4
    AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst) $past(sleep) |-> $stable(dq_out)); // R3
    AST_BUS_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst) (oe_n || ce_n) |-> !dq_oe); // R5
    AST_BUS_OFF_IN_RESET: assert property (@(posedge clk) disable iff (rst) pin_low |-> !dq_oe); // R8
    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (rst) pin_low |=> !wr_strobe); // R8
    AST_ENGINE_BUSY_SHOWN: assert property (@(posedge clk) disable iff (rst) engine_busy |-> rb_busy); // R13
endmodule

bind flash_ctl_front fsc_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .oe_n         (oe_n),
    .ce_n         (ce_n),
    .engine_busy  (engine_busy),
    .pin_low      (pin_low_s),
    .sleep        (sleep),
    .dq_out       (dq_out),
    .dq_oe        (dq_oe),
    .rb_busy      (rb_busy),
    .engine_abort (engine_abort),
    .wr_strobe    (wr_strobe)
);

// File: tb/flash_ctl_front_test.sv
`timescale 1ns/1ps
module flash_ctl_front_test;
    localparam int AW = 8, DW = 8;
    localparam int RP_CYC = 5, READY_CYC = 20, RH_CYC = 4;
    localparam int ACC_CYC = 6, MARGIN_CYC = 8;
    localparam int SLEEP_CYC = ACC_CYC + MARGIN_CYC;

    // vector: {addr[7:0], ce_n, oe_n, expected dq_oe}
    localparam int NVEC = 8;
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h12, 1'b0, 1'b0, 1'b1},
        {8'h34, 1'b0, 1'b1, 1'b0},
        {8'h56, 1'b1, 1'b0, 1'b0},
        {8'h78, 1'b0, 1'b0, 1'b1},
        {8'h9A, 1'b1, 1'b1, 1'b0},
        {8'hBC, 1'b0, 1'b0, 1'b1},
        {8'hDE, 1'b0, 1'b0, 1'b1},
        {8'hF0, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1, rst_pin_n = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, engine_busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] salt = 8'hA5;
    logic [DW-1:0] array_rdata, dq_out;
    logic dq_oe, rb_busy, sleep, engine_abort, wr_strobe;
    int compared = 0, mismatched = 0;
    int abort_seen = 0, wr_seen = 0, busy_seen = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a, input logic [DW-1:0] s);
        return {a[3:0], a[7:4]} ^ s;
    endfunction

    assign array_rdata = model(addr, salt);

    flash_ctl_front #(
        .AW(AW), .DW(DW), .RP_CYC(RP_CYC), .READY_CYC(READY_CYC),
        .RH_CYC(RH_CYC), .ACC_CYC(ACC_CYC), .MARGIN_CYC(MARGIN_CYC)
    ) uut (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .engine_busy(engine_busy), .array_rdata(array_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe), .rb_busy(rb_busy), .sleep(sleep),
        .engine_abort(engine_abort), .wr_strobe(wr_strobe)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (engine_abort) abort_seen++;
            if (wr_strobe)    wr_seen++;
            if (rb_busy)      busy_seen++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges_to_sleep(input bit wiggle, output int k);
        k = 0;
        while (!sleep && k < 100) begin
            if (wiggle) begin
                ce_n = ~ce_n; oe_n = ~oe_n; we_n = ~we_n;
            end
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int k, a0, w0, b0;
        cycles(4);
        rst = 1'b0;
        @(negedge clk);
        check("reset sleep", {31'b0, sleep}, 0);
        check("reset abort R6", {31'b0, engine_abort}, 0);
        check("reset busy R13", {31'b0, rb_busy}, 0);
        check("reset strobe R12", {31'b0, wr_strobe}, 0);

        // R5: vector walk
        for (int i = 0; i < NVEC; i++) begin
            addr = VEC[i][10:3]; ce_n = VEC[i][2]; oe_n = VEC[i][1];
            cycles(3);
            check("R5 dq_oe", {31'b0, dq_oe}, {31'b0, VEC[i][0]});
            if (VEC[i][0]) check("R5 dq_out", {24'b0, dq_out}, {24'b0, model(VEC[i][10:3], salt)});
        end

        // R1: sleep entry edge count, quiet controls
        ce_n = 1'b0; oe_n = 1'b0;
        addr = 8'h21;
        edges_to_sleep(1'b0, k);
        check("R1 sleep edges", k, SLEEP_CYC + 1);

        // R3: data latched while asleep
        salt = 8'h3C;
        cycles(3);
        check("R3 held data", {24'b0, dq_out}, {24'b0, model(8'h21, 8'hA5)});
        check("R3 bus driven", {31'b0, dq_oe}, 1);

        // R4: wake on address change
        addr = 8'h43;
        @(negedge clk);
        check("R4 wake", {31'b0, sleep}, 0);
        cycles(2);
        check("R4 new data", {24'b0, dq_out}, {24'b0, model(8'h43, 8'h3C)});

        // R2: entry with control pins toggling
        addr = 8'h65;
        edges_to_sleep(1'b1, k);
        check("R2 sleep edges with controls", k, SLEEP_CYC + 1);
        for (int i = 0; i < 8; i++) begin
            ce_n = ~ce_n; oe_n = ~oe_n; we_n = ~we_n;
            @(negedge clk);
            check("R2 stays asleep", {31'b0, sleep}, 1);
        end
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        addr = 8'h66;
        cycles(3);

        // R12: one write strobe
        w0 = wr_seen;
        we_n = 1'b0; cycles(2); we_n = 1'b1; cycles(3);
        check("R12 strobe count", wr_seen - w0, 1);

        // R13: engine busy alone
        engine_busy = 1'b1; @(negedge clk);
        check("R13 busy follows engine", {31'b0, rb_busy}, 1);
        engine_busy = 1'b0; @(negedge clk);
        check("R13 busy clears", {31'b0, rb_busy}, 0);

        // R7: short pulse ignored
        a0 = abort_seen; b0 = busy_seen;
        rst_pin_n = 1'b0; cycles(2); rst_pin_n = 1'b1;
        cycles(8);
        check("R7 no abort", abort_seen - a0, 0);
        check("R7 no busy", busy_seen - b0, 0);
        check("R7 bus back", {31'b0, dq_oe}, 1);

        // R6/R9: long reset while engine busy
        engine_busy = 1'b1;
        a0 = abort_seen;
        rst_pin_n = 1'b0;
        k = 0;
        while (!engine_abort && k < 30) begin @(negedge clk); k++; end
        engine_busy = 1'b0;
        check("R9 busy at abort", {31'b0, rb_busy}, 1);
        cycles(READY_CYC - 1);
        check("R9 busy stretched", {31'b0, rb_busy}, 1);
        @(negedge clk);
        check("R9 busy ends", {31'b0, rb_busy}, 0);
        check("R6 single abort", abort_seen - a0, 1);

        // R11: recovery delay
        rst_pin_n = 1'b1;
        k = 0;
        while (!dq_oe && k < 40) begin @(negedge clk); k++; end
        check("R11 recovery edges", k, RH_CYC + 3);

        // R10/R8: reset with engine idle, write attempt during reset
        a0 = abort_seen; b0 = busy_seen; w0 = wr_seen;
        rst_pin_n = 1'b0;
        cycles(10);
        check("R8 bus off in reset", {31'b0, dq_oe}, 0);
        we_n = 1'b0; cycles(2); we_n = 1'b1; cycles(3);
        check("R8 no write in reset", wr_seen - w0, 0);
        check("R10 no busy", busy_seen - b0, 0);
        check("R6 abort idle", abort_seen - a0, 1);
        rst_pin_n = 1'b1;
        cycles(RH_CYC + 4);
        check("R11 bus restored", {31'b0, dq_oe}, 1);
        check("R5 data after reset", {24'b0, dq_out}, {24'b0, model(addr, salt)});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule